// File: doc/BRIEF.md
# Indirect Command Bridge

This block lets a host that only speaks 64-bit register accesses run single transactions on an internal bus with a 32-bit address. The host sees four 64-bit slots. It first parks a write word in the data slot. It then writes a command word to the control slot. The command carries a direction flag, a byte count and the downstream address. The bridge decodes the command and drives one request on the downstream bus. It holds that request until the bus acknowledges it.

When the acknowledge arrives, the bridge records a completion word in the status slot. For a read, the completion word also holds the returned data, or all ones if the bus flagged an error. The host polls the status slot. Each read of that slot hands back its content and empties it. The downstream side is a plain request / acknowledge / error handshake, with byte lanes ordered so that the first byte sits in the top lane.

Top module: `ind_cmd_bridge`

## Requirements
- R1: Byte-address bits [4:3] pick the slot: 0 control, 1 reset, 2 status, 3 data. Every access is a full 64-bit word. A read of the control or reset slot returns zero.
- R2: A control write whose byte count (bits [59:56]) is 8 or less starts one downstream access on the next cycle. The access takes its address from bits [31:0], and bit 48 set means read (ds_we low), clear means write.
- R3: A control write whose byte count is above 8 starts no downstream access and leaves the status slot unchanged.
- R4: A data-slot write keeps bits [63:32] of the written word. A data-slot read returns that word in bits [63:32] with zeros in [31:0].
- R5: Write data goes out big-endian on ds_wdata. Bits [63:32] carry the data word, its bits [31:24] in the first byte lane [63:56]. Bits [31:0] are zero.
- R6: When a read completes without error, status becomes bit 11 set plus ds_rdata[63:32] placed in status bits [57:26], with every other bit zero.
- R7: When a read completes with an error, status becomes bit 11 set plus all ones in bits [57:26].
- R8: When a write completes, status becomes bit 11 alone, whether or not ds_err was set.
- R9: A status-slot read returns the status word and clears it to zero in the same access. A completion in that cycle takes priority over the clear.
- R10: Writes to the status slot and to the reset slot change neither status nor the data slot, and they start nothing.
- R11: busy and ds_req rise on the cycle after a launch. ds_req and its address, direction, size and data hold until the cycle in which ds_ack is sampled, after which both fall. Control writes while busy are ignored, and ds_ack while idle has no effect.
- R12: A read access returns reg_rdata with reg_rvalid high on the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_req | input | 1 | Register access strobe, one cycle per access |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | REG_AW | Byte address; bits [4:3] select the slot |
| reg_wdata | input | 64 | Write word |
| reg_rdata | output | 64 | Read word, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after the request |
| ds_req | output | 1 | Downstream request, held until acknowledged |
| ds_we | output | 1 | Downstream direction, 1 = write |
| ds_addr | output | 32 | Downstream address |
| ds_size | output | 4 | Downstream byte count |
| ds_wdata | output | 64 | Downstream write lanes, first byte in [63:56] |
| ds_ack | input | 1 | Downstream acknowledge, one cycle |
| ds_err | input | 1 | Downstream error, qualified by ds_ack |
| ds_rdata | input | 64 | Downstream read lanes, first byte in [63:56] |
| busy | output | 1 | A downstream access is outstanding |

## Verification
A control write sampled at one edge shows up as ds_req, busy and the address and data lanes one cycle later. An acknowledge sampled at an edge updates status and drops busy at that same edge. A read request returns its data with reg_rvalid one edge later. The bench holds a behavioural model that advances on the same edges. Stimulus changes and all comparisons happen on the falling edge, so each registered result is checked in the half-cycle right after the edge that made it. Directed reads of the status and data slots then check the packed completion words, dropped commands and ignored writes against constants worked out from the requirements.

// File: rtl/icb_pkg.sv
// Package: shared field layout and types of the indirect command bridge.
// Assumes 64-bit register words and a 32-bit downstream address.
package icb_pkg;

    localparam int WORD_W      = 64;
    localparam int DS_AW       = 32;
    localparam int DWORD_W     = 32;
    localparam int CNT_W       = 4;
    localparam int CTL_RD_BIT  = 48;
    localparam int CTL_CNT_LSB = 56;
    localparam int ST_DONE_BIT = 11;
    localparam int ST_RD_LSB   = 26;
    localparam int LANES       = WORD_W / 8;

    typedef enum logic [1:0] {
        SLOT_CTL  = 2'd0,
        SLOT_RST  = 2'd1,
        SLOT_STAT = 2'd2,
        SLOT_DATA = 2'd3
    } slot_e;

    typedef struct packed {
        logic               is_read;
        logic [CNT_W-1:0]   nbytes;
        logic [DS_AW-1:0]   addr;
    } cmd_t;

endpackage

// File: rtl/icb_cmd_decode.sv
// Module: splits a control word into direction, byte count and address,
// and flags whether the byte count is within the supported maximum.
// Assumes the field positions held in icb_pkg.
module icb_cmd_decode
    import icb_pkg::*;
#(
    parameter int MAX_BYTES = 8
) (
    input  logic [WORD_W-1:0] word,
    output cmd_t              cmd,
    output logic              legal
);

    logic unused_bits;

    // Field extraction from the control word.
    always_comb begin
        cmd.is_read = word[CTL_RD_BIT];
        cmd.nbytes  = word[CTL_CNT_LSB +: CNT_W];
        cmd.addr    = word[DS_AW-1:0];
        legal       = ({28'd0, cmd.nbytes} <= 32'(MAX_BYTES));
    end

    assign unused_bits = ^{word[63:60], word[55:49], word[47:32]};

endmodule

// File: rtl/icb_ds_master.sv
// Module: owns one downstream transaction at a time. Latches a command
// on launch, holds the request until acknowledged, and reports the
// completion in the acknowledge cycle. Assumes ds_ack is a one-cycle pulse.
module icb_ds_master
    import icb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  cmd_t               cmd,
    input  logic [DWORD_W-1:0] data_word,
    input  logic               ds_ack,
    input  logic               ds_err,
    input  logic [WORD_W-1:0]  ds_rdata,
    output logic               ds_req,
    output logic               ds_we,
    output logic [DS_AW-1:0]   ds_addr,
    output logic [CNT_W-1:0]   ds_size,
    output logic [WORD_W-1:0]  ds_wdata,
    output logic               busy,
    output logic               done,
    output logic               done_is_read,
    output logic               done_err,
    output logic [DWORD_W-1:0] done_rdata
);

    localparam int DATA_LANES = DWORD_W / 8;

    logic                req_q;
    logic                we_q;
    logic [DS_AW-1:0]    addr_q;
    logic [CNT_W-1:0]    size_q;
    logic [WORD_W-1:0]   lanes_q;
    logic [WORD_W-1:0]   lanes_d;
    logic                accept;
    logic                unused_lo;

    assign accept = launch && !req_q;

    // Byte-lane packing: data word bytes fill the top lanes, the rest are zero.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g < DATA_LANES) begin : g_data
            assign lanes_d[WORD_W-1-8*g -: 8] = data_word[DWORD_W-1-8*g -: 8];
        end else begin : g_zero
            assign lanes_d[WORD_W-1-8*g -: 8] = 8'h00;
        end
    end

    // Request state: set on accepted launch, cleared on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (accept) begin
            req_q <= 1'b1;
        end else if (req_q && ds_ack) begin
            req_q <= 1'b0;
        end
    end

    // Command capture: held stable for the whole transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            size_q  <= '0;
            lanes_q <= '0;
        end else if (accept) begin
            we_q    <= !cmd.is_read;
            addr_q  <= cmd.addr;
            size_q  <= cmd.nbytes;
            lanes_q <= lanes_d;
        end
    end

    assign ds_req       = req_q;
    assign ds_we        = we_q;
    assign ds_addr      = addr_q;
    assign ds_size      = size_q;
    assign ds_wdata     = lanes_q;
    assign busy         = req_q;
    assign done         = req_q && ds_ack;
    assign done_is_read = !we_q;
    assign done_err     = ds_err;
    assign done_rdata   = ds_rdata[WORD_W-1 -: DWORD_W];
    assign unused_lo    = ^ds_rdata[WORD_W-DWORD_W-1:0];

endmodule

// File: rtl/icb_slot_regs.sv
// Module: the host-visible slots. Holds the data word and the status
// word, builds read responses one cycle after a read request, and
// raises a strobe on control writes. Assumes one access per cycle.
module icb_slot_regs
    import icb_pkg::*;
#(
    parameter int REG_AW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_req,
    input  logic               acc_we,
    input  logic [REG_AW-1:0]  acc_addr,
    input  logic [WORD_W-1:0]  acc_wdata,
    input  logic               done,
    input  logic               done_is_read,
    input  logic               done_err,
    input  logic [DWORD_W-1:0] done_rdata,
    output logic               ctl_wr,
    output logic [DWORD_W-1:0] data_word,
    output logic [WORD_W-1:0]  status,
    output logic [WORD_W-1:0]  rdata,
    output logic               rvalid
);

    slot_e               slot;
    logic                rd_acc;
    logic                wr_acc;
    logic [DWORD_W-1:0]  data_q;
    logic [WORD_W-1:0]   status_q;
    logic [WORD_W-1:0]   done_word;
    logic [WORD_W-1:0]   rd_mux;
    logic [WORD_W-1:0]   rdata_q;
    logic                rvalid_q;
    logic                unused_addr;

    assign slot   = slot_e'(acc_addr[4:3]);
    assign rd_acc = acc_req && !acc_we;
    assign wr_acc = acc_req && acc_we;
    assign ctl_wr = wr_acc && (slot == SLOT_CTL);

    // Completion word: done flag, plus read data or all ones for a read.
    always_comb begin
        done_word = '0;
        done_word[ST_DONE_BIT] = 1'b1;
        if (done_is_read) begin
            done_word[ST_RD_LSB +: DWORD_W] = done_err ? '1 : done_rdata;
        end
    end

    // Read multiplexer over the four slots.
    always_comb begin
        unique case (slot)
            SLOT_STAT: rd_mux = status_q;
            SLOT_DATA: rd_mux = {data_q, {(WORD_W-DWORD_W){1'b0}}};
            default:   rd_mux = '0;
        endcase
    end

    // Data slot: keeps the upper half of the written word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (wr_acc && (slot == SLOT_DATA)) begin
            data_q <= acc_wdata[WORD_W-1 -: DWORD_W];
        end
    end

    // Status slot: completion wins over read-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (done) begin
            status_q <= done_word;
        end else if (rd_acc && (slot == SLOT_STAT)) begin
            status_q <= '0;
        end
    end

    // Read response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd_acc;
            if (rd_acc) begin
                rdata_q <= rd_mux;
            end
        end
    end

    assign data_word   = data_q;
    assign status      = status_q;
    assign rdata       = rdata_q;
    assign rvalid      = rvalid_q;
    assign unused_addr = ^{acc_addr[REG_AW-1:5], acc_addr[2:0], acc_wdata[WORD_W-DWORD_W-1:0]};

endmodule

// File: rtl/ind_cmd_bridge.sv
// Module: top of the indirect command bridge. Joins the slot registers,
// the command decoder and the downstream master. Assumes a single
// downstream target that always eventually acknowledges.
module ind_cmd_bridge
    import icb_pkg::*;
#(
    parameter int REG_AW    = 8,
    parameter int MAX_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic              reg_rvalid,
    output logic              ds_req,
    output logic              ds_we,
    output logic [31:0]       ds_addr,
    output logic [3:0]        ds_size,
    output logic [63:0]       ds_wdata,
    input  logic              ds_ack,
    input  logic              ds_err,
    input  logic [63:0]       ds_rdata,
    output logic              busy
);

    cmd_t                cmd;
    logic                legal;
    logic                ctl_wr;
    logic [DWORD_W-1:0]  data_word;
    logic [WORD_W-1:0]   status;
    logic                done;
    logic                done_is_read;
    logic                done_err;
    logic [DWORD_W-1:0]  done_rdata;

    icb_cmd_decode #(.MAX_BYTES(MAX_BYTES)) u_dec (
        .word  (reg_wdata),
        .cmd   (cmd),
        .legal (legal)
    );

    icb_slot_regs #(.REG_AW(REG_AW)) u_slots (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_req      (reg_req),
        .acc_we       (reg_we),
        .acc_addr     (reg_addr),
        .acc_wdata    (reg_wdata),
        .done         (done),
        .done_is_read (done_is_read),
        .done_err     (done_err),
        .done_rdata   (done_rdata),
        .ctl_wr       (ctl_wr),
        .data_word    (data_word),
        .status       (status),
        .rdata        (reg_rdata),
        .rvalid       (reg_rvalid)
    );

    icb_ds_master u_ds (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch       (ctl_wr && legal),
        .cmd          (cmd),
        .data_word    (data_word),
        .ds_ack       (ds_ack),
        .ds_err       (ds_err),
        .ds_rdata     (ds_rdata),
        .ds_req       (ds_req),
        .ds_we        (ds_we),
        .ds_addr      (ds_addr),
        .ds_size      (ds_size),
        .ds_wdata     (ds_wdata),
        .busy         (busy),
        .done         (done),
        .done_is_read (done_is_read),
        .done_err     (done_err),
        .done_rdata   (done_rdata)
    );

endmodule

// File: rtl/icb_chk.sv
// Module: protocol checker for the indirect command bridge, bound to the top.
module icb_chk #(
    parameter int REG_AW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_req,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [63:0]       reg_wdata,
    input logic [63:0]       reg_rdata,
    input logic              reg_rvalid,
    input logic              ds_req,
    input logic              ds_we,
    input logic [31:0]       ds_addr,
    input logic [3:0]        ds_size,
    input logic              ds_ack,
    input logic              busy
);

    // R2
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we && reg_addr[4:3] == 2'd0 && reg_wdata[59:56] <= 4'd8 && !busy)
        |=> (ds_req && ds_addr == $past(reg_wdata[31:0]) && ds_we == !$past(reg_wdata[48])));

    // R3
    drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we && reg_addr[4:3] == 2'd0 && reg_wdata[59:56] > 4'd8 && !busy)
        |=> !ds_req);

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_req && !ds_ack) |=> (ds_req && $stable(ds_addr) && $stable(ds_we) && $stable(ds_size)));

    // R11
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_req && ds_ack) |=> (!ds_req && !busy));

    // R12
    rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_we) |=> reg_rvalid);

    // R1
    zero_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_we && !reg_addr[4]) |=> (reg_rdata == 64'd0));

    // R4
    data_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_we && reg_addr[4:3] == 2'd3) |=> (reg_rdata[31:0] == 32'd0));

endmodule

bind ind_cmd_bridge icb_chk #(.REG_AW(REG_AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_req    (reg_req),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid),
    .ds_req     (ds_req),
    .ds_we      (ds_we),
    .ds_addr    (ds_addr),
    .ds_size    (ds_size),
    .ds_ack     (ds_ack),
    .busy       (busy)
);

// File: tb/ind_cmd_bridge_tb.sv
`timescale 1ns/1ps
// Bench: behavioural model stepped on each rising edge, compared on each
// falling edge, plus directed slot reads against hand-computed words.
module ind_cmd_bridge_tb;

    localparam int REG_AW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_req = 1'b0;
    logic              reg_we = 1'b0;
    logic [REG_AW-1:0] reg_addr = '0;
    logic [63:0]       reg_wdata = '0;
    logic [63:0]       reg_rdata;
    logic              reg_rvalid;
    logic              ds_req;
    logic              ds_we;
    logic [31:0]       ds_addr;
    logic [3:0]        ds_size;
    logic [63:0]       ds_wdata;
    logic              ds_ack = 1'b0;
    logic              ds_err = 1'b0;
    logic [63:0]       ds_rdata = '0;
    logic              busy;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit ended = 0;

    // model state
    bit          m_busy;
    bit          m_we;
    logic [31:0] m_addr;
    logic [3:0]  m_size;
    logic [63:0] m_wdata;
    logic [31:0] m_data;
    logic [63:0] m_status;
    logic [63:0] m_rdata;
    bit          m_rvalid;

    always #2.5 clk = ~clk;

    ind_cmd_bridge #(.REG_AW(REG_AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .ds_req(ds_req), .ds_we(ds_we),
        .ds_addr(ds_addr), .ds_size(ds_size), .ds_wdata(ds_wdata),
        .ds_ack(ds_ack), .ds_err(ds_err), .ds_rdata(ds_rdata), .busy(busy)
    );

    task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    // Reference model, advanced on the same edges as the design.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_busy = 0; m_we = 0; m_addr = 0; m_size = 0; m_wdata = 0;
            m_data = 0; m_status = 0; m_rdata = 0; m_rvalid = 0;
        end else begin
            bit          was_busy;
            logic [63:0] fin;
            bit          fin_v;
            was_busy = m_busy;
            fin_v = 0;
            fin = 0;
            if (m_busy && ds_ack) begin
                fin_v = 1;
                fin = 64'd1 << 11;
                if (!m_we) fin = fin | ((ds_err ? 64'hFFFF_FFFF : {32'd0, ds_rdata[63:32]}) << 26);
                m_busy = 0;
            end
            m_rvalid = reg_req && !reg_we;
            if (reg_req && !reg_we) begin
                case (reg_addr[4:3])
                    2'd2: begin m_rdata = m_status; m_status = 0; end
                    2'd3: m_rdata = {m_data, 32'd0};
                    default: m_rdata = 0;
                endcase
            end
            if (reg_req && reg_we && reg_addr[4:3] == 2'd0 && !was_busy && reg_wdata[59:56] <= 4'd8) begin
                m_busy = 1; m_we = !reg_wdata[48]; m_addr = reg_wdata[31:0];
                m_size = reg_wdata[59:56]; m_wdata = {m_data, 32'd0};
            end
            if (reg_req && reg_we && reg_addr[4:3] == 2'd3) m_data = reg_wdata[63:32];
            if (fin_v) m_status = fin;
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (!ended && cyc > 0) begin
            cmp("R11 ds_req", {63'd0, ds_req}, {63'd0, m_busy});
            cmp("R11 busy", {63'd0, busy}, {63'd0, m_busy});
            cmp("R2 ds_we", {63'd0, ds_we}, {63'd0, m_we});
            cmp("R2 ds_addr", {32'd0, ds_addr}, {32'd0, m_addr});
            cmp("R2 ds_size", {60'd0, ds_size}, {60'd0, m_size});
            cmp("R5 ds_wdata", ds_wdata, m_wdata);
            cmp("R12 reg_rvalid", {63'd0, reg_rvalid}, {63'd0, m_rvalid});
            cmp("R9 reg_rdata", reg_rdata, m_rdata);
        end
    end

    task automatic reg_wr(input logic [1:0] slot, input logic [63:0] w);
        @(negedge clk);
        reg_req = 1; reg_we = 1; reg_addr = {3'b101, slot, 3'b000}; reg_wdata = w;
        @(negedge clk);
        reg_req = 0; reg_we = 0;
    endtask

    task automatic reg_rd(input logic [1:0] slot, output logic [63:0] r);
        @(negedge clk);
        reg_req = 1; reg_we = 0; reg_addr = {3'b000, slot, 3'b000};
        @(negedge clk);
        reg_req = 0;
        r = reg_rdata;
    endtask

    task automatic respond(input int lat, input bit err, input logic [31:0] rd);
        repeat (lat) @(negedge clk);
        ds_ack = 1; ds_err = err; ds_rdata = {rd, 32'h0BAD_F00D};
        @(negedge clk);
        ds_ack = 0; ds_err = 0; ds_rdata = '0;
    endtask

    function automatic logic [63:0] ctl(input bit rd, input logic [3:0] n, input logic [31:0] a);
        logic [63:0] w;
        w = 64'hF000_0000_0000_0000 & 64'h0;
        w[48] = rd;
        w[59:56] = n;
        w[31:0] = a;
        return w;
    endfunction

    task automatic finish_run;
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [63:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state
        cmp("R11 reset busy", {63'd0, busy}, 64'd0);
        reg_rd(2'd0, r); cmp("R1 control read", r, 64'd0);
        reg_rd(2'd1, r); cmp("R1 reset-slot read", r, 64'd0);
        reg_rd(2'd2, r); cmp("R9 status after reset", r, 64'd0);

        // data slot
        reg_wr(2'd3, 64'hA1B2_C3D4_5566_7788);
        reg_rd(2'd3, r); cmp("R4 data readback", r, 64'hA1B2_C3D4_0000_0000);

        // write command, error reported by downstream
        reg_wr(2'd0, ctl(0, 4'd4, 32'h1234_5678));
        cmp("R5 write lanes", ds_wdata, 64'hA1B2_C3D4_0000_0000);
        cmp("R2 write dir", {63'd0, ds_we}, 64'd1);
        respond(2, 1, 32'h0);
        reg_rd(2'd2, r); cmp("R8 write done", r, 64'h0000_0000_0000_0800);
        reg_rd(2'd2, r); cmp("R9 cleared", r, 64'd0);

        // successful read
        reg_wr(2'd0, ctl(1, 4'd4, 32'hD001_0060));
        cmp("R2 read dir", {63'd0, ds_we}, 64'd0);
        respond(1, 0, 32'hDEAD_BEEF);
        reg_rd(2'd2, r); cmp("R6 read done", r, (64'h800 | (64'hDEAD_BEEF << 26)));

        // failed read
        reg_wr(2'd0, ctl(1, 4'd1, 32'h0000_0010));
        respond(3, 1, 32'h1357_9BDF);
        reg_rd(2'd2, r); cmp("R7 read error", r, (64'h800 | (64'hFFFF_FFFF << 26)));

        // leave a status word pending, then an over-size command
        reg_wr(2'd0, ctl(1, 4'd8, 32'hCAFE_0008));
        cmp("R2 size 8 launches", {63'd0, ds_req}, 64'd1);
        respond(1, 0, 32'h0102_0304);
        reg_wr(2'd0, ctl(1, 4'd9, 32'h9999_9999));
        cmp("R3 size 9 dropped", {63'd0, ds_req}, 64'd0);
        reg_wr(2'd0, ctl(0, 4'd15, 32'h8888_8888));
        cmp("R3 size 15 dropped", {63'd0, ds_req}, 64'd0);

        // ignored writes, ack while idle
        reg_wr(2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
        reg_wr(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
        respond(0, 1, 32'h5555_5555);
        reg_rd(2'd2, r); cmp("R10 status kept", r, (64'h800 | (64'h0102_0304 << 26)));
        reg_rd(2'd3, r); cmp("R10 data kept", r, 64'hA1B2_C3D4_0000_0000);

        // busy: second control write ignored
        reg_wr(2'd3, 64'h0F1E_2D3C_0000_0000);
        reg_wr(2'd0, ctl(0, 4'd0, 32'h0000_AAAA));
        reg_wr(2'd0, ctl(1, 4'd2, 32'h0000_BBBB));
        cmp("R11 addr held", {32'd0, ds_addr}, 64'h0000_AAAA);
        cmp("R11 still busy", {63'd0, busy}, 64'd1);
        respond(2, 0, 32'h0);
        cmp("R11 released", {63'd0, busy}, 64'd0);
        reg_rd(2'd2, r); cmp("R8 size 0 write done", r, 64'h800);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule